// File: doc/BRIEF.md
# Parallel-to-Serial Transmitter with Synchronization Bursts

This block is the digital front end of a serial link transmitter. A parallel word arrives alongside a slow transmit clock. The block samples that clock with a fast bit clock and captures the word on whichever transmit-clock edge the edge-select pin picks. It then shifts the word out one bit per bit-clock cycle as back-to-back symbols, most significant bit first. A new word is taken in only at a symbol boundary, so a symbol is never cut short.

Either of two sync request pins starts a burst of synchronization symbols. Each sync symbol is five ones followed by five zeros. A burst never runs shorter than a fixed minimum, 1024 symbols by default, even if the request drops at once. The burst goes on for as long as either request stays high. The output enable turns off the output drive while shifting continues underneath. The active-low power-down pin puts the block to sleep. On waking, the block starts again from a clean symbol boundary. High impedance is modelled as a drive-enable flag, with the data bit held at zero whenever the output is not driven.

Top module: `ser_sync_tx`

## Requirements
- R1: The word on `din` is captured on a rising `tx_clk` edge when `edge_rise_sel` is 1, and on a falling edge when it is 0. An edge of the other polarity leaves the held word unchanged.
- R2: Symbols are `WORD_W` (10) bits long and are sent back to back, one bit per `clk` cycle, most significant bit first. Each symbol is the held word as it stood at that symbol's boundary. The first symbol starts on the first clock edge after reset or wake-up.
- R3: The two request pins `sync_req_a` and `sync_req_b` act as one request, formed by logical OR.
- R4: A rising request sends at least `BURST_MIN` (1024) sync symbols of value 10'b1111100000, even when the request is high for a single cycle. For such a short request the burst is exactly 1024 symbols, after which data symbols resume.
- R5: While the combined request stays high, every symbol sent is a sync symbol, including those beyond the minimum count.
- R6: `sync_busy` is 1 exactly while a sync symbol is being shifted out, and it changes only at symbol boundaries.
- R7: When `out_en` is 0, `drive_en` is 0 and `ser_out` is 0. Shifting continues, so symbol timing is unchanged when the output is enabled again.
- R8: When `pd_n` is 0, the block sleeps. `drive_en`, `ser_out` and `sync_busy` are 0, no word is captured, and the burst count is cleared.
- R9: After `pd_n` returns to 1, the first symbol is a complete data symbol holding the word captured before sleep, and `drive_en` is 1 when `out_en` is 1.
- R10: While `rst_n` is low, `drive_en`, `ser_out` and `sync_busy` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one serial bit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_clk | input | 1 | Transmit word clock, sampled by `clk` |
| edge_rise_sel | input | 1 | 1: capture on rising `tx_clk` edge; 0: on falling edge |
| din | input | WORD_W | Parallel data word |
| sync_req_a | input | 1 | Sync burst request, first pin |
| sync_req_b | input | 1 | Sync burst request, second pin |
| out_en | input | 1 | Output enable; 0 releases the output |
| pd_n | input | 1 | Active-low power-down |
| ser_out | output | 1 | Serial data bit, 0 when not driven |
| drive_en | output | 1 | Output is driven (0 models high impedance) |
| sync_busy | output | 1 | A sync symbol is currently on the line |

## Verification
The hardest case to reach from the ports is the end of a minimum-length burst after a one-cycle request. The request is gone long before the count runs out, so the only visible sign is the exact number of sync symbols before data resumes. The bench drives a single-cycle pulse and then lets more than ten thousand bit clocks pass. A monitor rebuilds symbols from the serial stream and measures the run of sync patterns, which must be exactly 1024. A second hard case is sleep entered partway through a burst: the bench powers down during a burst and checks that the first symbol after wake-up is the old data word and not a leftover sync symbol.

// File: rtl/ser_sync_pkg.sv
package ser_sync_pkg;

   // Kind of symbol currently held in the shift register.
   typedef enum logic {
      SYM_DATA = 1'b0,
      SYM_SYNC = 1'b1
   } sym_kind_e;

   // Bit value of the sync pattern at position pos for a symbol of the given
   // width: upper half ones, lower half zeros.
   function automatic logic sync_bit(input int width, input int pos);
      return (pos >= width / 2);
   endfunction

endpackage

// File: rtl/ser_word_capture.sv
// Samples the transmit word clock with the bit clock and captures the data
// word on the selected edge polarity.
module ser_word_capture #(
   parameter int WORD_W      = 10,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              awake,
   input  logic              tx_clk,
   input  logic              rise_sel,
   input  logic [WORD_W-1:0] din,
   output logic [WORD_W-1:0] word_q
);

   if (SYNC_STAGES < 1) begin : g_bad_stages
      $error("ser_word_capture: SYNC_STAGES must be at least 1");
   end
   if (WORD_W < 2) begin : g_bad_width
      $error("ser_word_capture: WORD_W must be at least 2");
   end

   localparam int LAST = SYNC_STAGES - 1;

   logic [SYNC_STAGES-1:0] clk_pipe;
   logic [WORD_W-1:0]      dat_pipe [SYNC_STAGES];
   logic                   clk_prev;
   logic                   ev_rise;
   logic                   ev_fall;
   logic                   take;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clk_pipe <= '0;
         clk_prev <= 1'b0;
         for (int i = 0; i < SYNC_STAGES; i++) dat_pipe[i] <= '0;
      end else begin
         clk_pipe[0] <= tx_clk;
         dat_pipe[0] <= din;
         for (int i = 1; i < SYNC_STAGES; i++) begin
            clk_pipe[i] <= clk_pipe[i-1];
            dat_pipe[i] <= dat_pipe[i-1];
         end
         clk_prev <= clk_pipe[LAST];
      end
   end

   assign ev_rise = clk_pipe[LAST] & ~clk_prev;
   assign ev_fall = ~clk_pipe[LAST] & clk_prev;
   assign take    = awake & (rise_sel ? ev_rise : ev_fall);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    word_q <= '0;
      else if (take) word_q <= dat_pipe[LAST];
   end

endmodule

// File: rtl/ser_burst_ctrl.sv
// Minimum-length sync burst counter with level extension.
module ser_burst_ctrl #(
   parameter int BURST_MIN = 1024,
   parameter int CNT_W     = $clog2(BURST_MIN + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             awake,
   input  logic             req,
   input  logic             boundary,
   output logic             want_sync,
   output logic [CNT_W-1:0] cnt_q
);

   if (BURST_MIN < 1) begin : g_bad_min
      $error("ser_burst_ctrl: BURST_MIN must be at least 1");
   end
   if ((1 << CNT_W) <= BURST_MIN) begin : g_bad_cnt
      $error("ser_burst_ctrl: CNT_W too narrow for BURST_MIN");
   end

   localparam logic [CNT_W-1:0] FULL  = CNT_W'(BURST_MIN);
   localparam logic [CNT_W-1:0] FIRST = CNT_W'(BURST_MIN - 1);

   logic req_q;
   logic rise;
   logic pending;

   assign rise      = req & ~req_q;
   assign pending   = (cnt_q != '0);
   assign want_sync = rise | pending | req;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req_q <= 1'b0;
      else        req_q <= req;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!awake) begin
         cnt_q <= '0;
      end else if (rise) begin
         // a symbol loaded on this edge already counts as the first one
         cnt_q <= boundary ? FIRST : FULL;
      end else if (boundary && pending) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

endmodule

// File: rtl/ser_shifter.sv
// Symbol shift register with a bit-position counter; loads only at the
// symbol boundary.
module ser_shifter
   import ser_sync_pkg::*;
#(
   parameter int WORD_W    = 10,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              awake,
   input  logic [WORD_W-1:0] load_word,
   input  sym_kind_e         load_kind,
   output logic              bit_out,
   output logic              boundary,
   output logic              primed,
   output sym_kind_e         cur_kind
);

   localparam int IDX_W = (WORD_W > 2) ? $clog2(WORD_W) : 1;
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORD_W - 1);

   logic [WORD_W-1:0] sh_q;
   logic [WORD_W-1:0] sh_next;
   logic [IDX_W-1:0]  idx_q;

   assign boundary = (idx_q == LAST_IDX);

   if (MSB_FIRST) begin : g_msb
      assign bit_out = sh_q[WORD_W-1];
      assign sh_next = {sh_q[WORD_W-2:0], 1'b0};
   end else begin : g_lsb
      assign bit_out = sh_q[0];
      assign sh_next = {1'b0, sh_q[WORD_W-1:1]};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q     <= '0;
         idx_q    <= LAST_IDX;
         primed   <= 1'b0;
         cur_kind <= SYM_DATA;
      end else if (!awake) begin
         sh_q     <= '0;
         idx_q    <= LAST_IDX;
         primed   <= 1'b0;
         cur_kind <= SYM_DATA;
      end else if (boundary) begin
         sh_q     <= load_word;
         idx_q    <= '0;
         primed   <= 1'b1;
         cur_kind <= load_kind;
      end else begin
         sh_q     <= sh_next;
         idx_q    <= idx_q + 1'b1;
      end
   end

endmodule

// File: rtl/ser_sync_tx.sv
// Top: parallel capture, burst control and serializer with drive gating.
module ser_sync_tx
   import ser_sync_pkg::*;
#(
   parameter int WORD_W      = 10,
   parameter int BURST_MIN   = 1024,
   parameter int SYNC_STAGES = 2,
   parameter bit MSB_FIRST   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_clk,
   input  logic              edge_rise_sel,
   input  logic [WORD_W-1:0] din,
   input  logic              sync_req_a,
   input  logic              sync_req_b,
   input  logic              out_en,
   input  logic              pd_n,
   output logic              ser_out,
   output logic              drive_en,
   output logic              sync_busy
);

   if (WORD_W % 2 != 0) begin : g_bad_even
      $error("ser_sync_tx: WORD_W must be even for the half/half sync pattern");
   end

   localparam int CNT_W = $clog2(BURST_MIN + 1);

   function automatic logic [WORD_W-1:0] make_sync();
      logic [WORD_W-1:0] r;
      for (int i = 0; i < WORD_W; i++) r[i] = sync_bit(WORD_W, i);
      return r;
   endfunction

   localparam logic [WORD_W-1:0] SYNC_WORD = make_sync();

   logic [WORD_W-1:0] held_word;
   logic [WORD_W-1:0] load_word;
   logic [CNT_W-1:0]  burst_cnt;
   logic              sync_req;
   logic              want_sync;
   logic              sym_boundary;
   logic              sh_bit;
   logic              primed;
   sym_kind_e         load_kind;
   sym_kind_e         cur_kind;

   assign sync_req = sync_req_a | sync_req_b;

   ser_word_capture #(
      .WORD_W     (WORD_W),
      .SYNC_STAGES(SYNC_STAGES)
   ) u_cap (
      .clk     (clk),
      .rst_n   (rst_n),
      .awake   (pd_n),
      .tx_clk  (tx_clk),
      .rise_sel(edge_rise_sel),
      .din     (din),
      .word_q  (held_word)
   );

   ser_burst_ctrl #(
      .BURST_MIN(BURST_MIN),
      .CNT_W    (CNT_W)
   ) u_burst (
      .clk      (clk),
      .rst_n    (rst_n),
      .awake    (pd_n),
      .req      (sync_req),
      .boundary (sym_boundary),
      .want_sync(want_sync),
      .cnt_q    (burst_cnt)
   );

   assign load_kind = want_sync ? SYM_SYNC : SYM_DATA;
   assign load_word = want_sync ? SYNC_WORD : held_word;

   ser_shifter #(
      .WORD_W   (WORD_W),
      .MSB_FIRST(MSB_FIRST)
   ) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .awake    (pd_n),
      .load_word(load_word),
      .load_kind(load_kind),
      .bit_out  (sh_bit),
      .boundary (sym_boundary),
      .primed   (primed),
      .cur_kind (cur_kind)
   );

   assign drive_en  = out_en & pd_n & primed;
   assign ser_out   = drive_en & sh_bit;
   assign sync_busy = pd_n & (cur_kind == SYM_SYNC);

endmodule

// File: rtl/ser_sync_tx_chk.sv
// Property checker attached to the top by bind.
module ser_sync_tx_chk #(
   parameter int BURST_MIN = 1024,
   parameter int CNT_W     = $clog2(BURST_MIN + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             sync_req_a,
   input logic             sync_req_b,
   input logic             out_en,
   input logic             pd_n,
   input logic             ser_out,
   input logic             drive_en,
   input logic             sync_busy,
   input logic             sym_boundary,
   input logic [CNT_W-1:0] burst_cnt
);

   localparam logic [CNT_W-1:0] FULL  = CNT_W'(BURST_MIN);
   localparam logic [CNT_W-1:0] FIRST = CNT_W'(BURST_MIN - 1);

   logic req;
   logic req_d;

   assign req = sync_req_a | sync_req_b;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req_d <= 1'b0;
      else        req_d <= req;
   end

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      burst_cnt <= FULL);  // R4

   AST_RISE_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (pd_n && req && !req_d) |=> (!pd_n || burst_cnt >= FIRST));  // R4

   AST_BURST_SENDS_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
      (pd_n && sym_boundary && burst_cnt != '0) |=> (!pd_n || sync_busy));  // R4

   AST_HELD_SENDS_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
      (pd_n && sym_boundary && req) |=> (!pd_n || sync_busy));  // R5

   AST_BUSY_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
      (pd_n && $past(pd_n) && !$past(sym_boundary)) |-> $stable(sync_busy));  // R6

   AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!out_en || !pd_n) |-> (!drive_en && !ser_out));  // R7

   AST_SLEEP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (!pd_n && $past(!pd_n)) |-> (burst_cnt == '0 && !sync_busy));  // R8

endmodule

bind ser_sync_tx ser_sync_tx_chk #(
   .BURST_MIN(BURST_MIN),
   .CNT_W    (CNT_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .sync_req_a  (sync_req_a),
   .sync_req_b  (sync_req_b),
   .out_en      (out_en),
   .pd_n        (pd_n),
   .ser_out     (ser_out),
   .drive_en    (drive_en),
   .sync_busy   (sync_busy),
   .sym_boundary(sym_boundary),
   .burst_cnt   (burst_cnt)
);

// File: tb/ser_sync_tx_tb.sv
module ser_sync_tx_tb;

   localparam logic [9:0] SYNC = 10'b1111100000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tx_clk = 1'b0;
   logic       edge_rise_sel = 1'b1;
   logic [9:0] din = '0;
   logic       sync_req_a = 1'b0;
   logic       sync_req_b = 1'b0;
   logic       out_en = 1'b1;
   logic       pd_n = 1'b1;
   logic       ser_out;
   logic       drive_en;
   logic       sync_busy;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   // serial-stream monitor state
   bit         mon_on = 1'b0;
   int         ph = 0;
   int         nsym = 0;
   int         run = 0;
   int         last_run = 0;
   logic [9:0] acc = '0;
   logic [9:0] last_sym = '0;
   logic [9:0] first_sym = '0;
   logic [9:0] exp_word = '0;

   always #10 clk = ~clk;  // 50 MHz

   ser_sync_tx u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .tx_clk       (tx_clk),
      .edge_rise_sel(edge_rise_sel),
      .din          (din),
      .sync_req_a   (sync_req_a),
      .sync_req_b   (sync_req_b),
      .out_en       (out_en),
      .pd_n         (pd_n),
      .ser_out      (ser_out),
      .drive_en     (drive_en),
      .sync_busy    (sync_busy)
   );

   always @(posedge clk) begin
      #2;
      if (mon_on) begin
         acc = {acc[8:0], ser_out};
         ph++;
         if (ph == 10) begin
            ph = 0;
            last_sym = acc;
            nsym++;
            if (nsym == 1) first_sym = acc;
            if (acc == SYNC) run++;
            else begin
               if (run > 0) last_run = run;
               run = 0;
            end
         end
      end
   end

   function automatic logic [9:0] pick_word();
      logic [9:0] w = 10'($urandom);
      if (w == SYNC) w = w ^ 10'h001;
      return w;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic restart_mon();
      mon_on = 1'b1;
      ph = 0;
      nsym = 0;
      run = 0;
      last_run = 0;
   endtask

   // Capture w on the chosen edge, then show junk across the opposite edge.
   task automatic send_word(input logic [9:0] w, input bit rise);
      edge_rise_sel = rise;
      idle(4);
      tx_clk = rise ? 1'b0 : 1'b1;
      idle(4);
      din = w;
      idle(3);
      tx_clk = rise ? 1'b1 : 1'b0;
      exp_word = w;
      idle(3);
      din = ~w;
      idle(3);
      tx_clk = rise ? 1'b0 : 1'b1;
      idle(35);
   endtask

   initial begin
      void'($urandom(32'h0000_5eed));
      idle(3);
      // R10: reset state
      chk(drive_en == 1'b0, "R10 drive_en", drive_en, 0);
      chk(ser_out == 1'b0, "R10 ser_out", ser_out, 0);
      chk(sync_busy == 1'b0, "R10 sync_busy", sync_busy, 0);
      rst_n = 1'b1;
      restart_mon();
      idle(12);
      // R2: first symbol after reset is the reset word, driven
      chk(nsym >= 1 && first_sym == 10'h000, "R2 first symbol", first_sym, 0);
      chk(drive_en == 1'b1, "R9 drive_en up", drive_en, 1);

      // directed: MSB-first order with an asymmetric word, both edges (R1, R2)
      send_word(10'h201, 1'b1);
      chk(last_sym == 10'h201, "R2 msb first", last_sym, 10'h201);
      send_word(10'h0F3, 1'b0);
      chk(last_sym == 10'h0F3, "R1 falling edge", last_sym, 10'h0F3);

      // random words and edges (R1: opposite edge ignored, R2: stream)
      for (int k = 0; k < 40; k++) begin
         logic [9:0] w = pick_word();
         bit r = 1'($urandom);
         send_word(w, r);
         chk(last_sym == exp_word, r ? "R1 rise capture" : "R1 fall capture",
             last_sym, exp_word);
      end

      // R7: output disabled, shifting continues
      out_en = 1'b0;
      idle(2);
      for (int k = 0; k < 5; k++) begin
         chk(!drive_en && !ser_out, "R7 released", {drive_en, ser_out}, 0);
         idle(7);
      end
      out_en = 1'b1;
      idle(30);
      chk(last_sym == exp_word, "R7 resumes aligned", last_sym, exp_word);

      // R4 + R3: one-cycle request on pin a gives exactly 1024 sync symbols
      send_word(10'h155, 1'b1);
      last_run = 0;
      sync_req_a = 1'b1;
      idle(1);
      sync_req_a = 1'b0;
      idle(5000);
      chk(sync_busy == 1'b1, "R6 busy mid burst", sync_busy, 1);
      chk(last_sym == SYNC, "R4 sync pattern", last_sym, SYNC);
      idle(5400);
      chk(last_run == 1024, "R4 minimum burst", last_run, 1024);
      chk(sync_busy == 1'b0, "R6 busy after burst", sync_busy, 0);
      chk(last_sym == 10'h155, "R2 data after burst", last_sym, 10'h155);

      // R5 + R3: request held on pin b beyond the minimum
      last_run = 0;
      sync_req_b = 1'b1;
      idle(15000);
      chk(sync_busy == 1'b1, "R5 still sync", sync_busy, 1);
      sync_req_b = 1'b0;
      idle(60);
      chk(last_run >= 1499 && last_run <= 1502, "R5 extended burst", last_run, 1500);
      chk(last_sym == 10'h155, "R5 data after release", last_sym, 10'h155);

      // R8/R9: sleep in the middle of a burst
      sync_req_a = 1'b1;
      idle(1);
      sync_req_a = 1'b0;
      idle(2000);
      pd_n = 1'b0;
      mon_on = 1'b0;
      idle(3);
      chk(!drive_en && !ser_out, "R8 asleep output", {drive_en, ser_out}, 0);
      chk(sync_busy == 1'b0, "R8 asleep busy", sync_busy, 0);
      // an edge while asleep must not be captured
      edge_rise_sel = 1'b1;
      tx_clk = 1'b0;
      idle(4);
      din = 10'h2C3;
      idle(3);
      tx_clk = 1'b1;
      idle(10);
      pd_n = 1'b1;
      restart_mon();
      idle(1);
      chk(drive_en == 1'b1, "R9 drive after wake", drive_en, 1);
      idle(11);
      chk(nsym >= 1 && first_sym == 10'h155, "R9 full data symbol", first_sym, 10'h155);
      chk(sync_busy == 1'b0, "R8 burst cleared", sync_busy, 0);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog act=0 exp=1");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule